// File: doc/BRIEF.md
# Loop Branch Predictor

This block predicts conditional branches that close loops. Such a branch goes the same way a fixed number of times and then goes the other way once. The block keeps a small, fully associative table. Each entry holds the branch address as its tag, a run counter, a learned trip limit, the dominant direction and a confidence flag. A lookup gives a hit flag and a direction in the same cycle. When the run counter has reached the learned limit, the predicted direction is the opposite of the dominant one. In every other case it is the dominant direction. Because the counter is compared with a learned trip count, the prediction flips exactly once per loop, even for trip counts far longer than any history register covers.

The resolve port reports each branch outcome after execution. When the main predictor has mispredicted, the caller raises the allocation request with the outcome. If the branch is not yet tracked, the block then claims an entry for it. Both ports are plain strobes with no back-pressure. The block takes one lookup and one resolve in every cycle, and it never stalls either port. A lookup sees the table as it stood before the resolve of the same cycle.

Top module: `loop_predictor`

## Requirements
- R1: With `lk_valid` high, `lk_hit` is high in the same cycle exactly when a confident entry's tag equals `lk_pc`; when `lk_hit` is low, `lk_taken` is 0. After reset no lookup hits.
- R2: A resolve of a tracked branch in its dominant direction raises that entry's run count by one, saturating at all ones.
- R3: A resolve of a tracked branch against its dominant direction returns its run count to zero, so the next prediction is the dominant direction again.
- R4: `lk_taken` is the inverse of the dominant direction when the run count equals the learned limit, and the dominant direction otherwise (1 = taken).
- R5: The first exit of an entry stores its run count as the limit. A later exit at a different count stores the new count and clears confidence, so `lk_hit` falls until the new count repeats.
- R6: Confidence, and therefore `lk_hit`, is set only by an exit whose count equals a limit already learned: two consecutive exits with the same trip count.
- R7: A resolve with `rs_alloc` high for an untracked address creates an entry with that outcome as the dominant direction, a run count of 1 and no confidence. `rs_alloc` is ignored for an address that is already tracked.
- R8: Allocation takes a free entry first. When the table is full, it replaces the entry whose last resolve or allocation is the oldest.
- R9: Once trained, loops with trip counts up to 255 are predicted with no mispredict on any outcome.
- R10: A resolve of an untracked address with `rs_alloc` low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Address of the branch looked up |
| lk_hit | output | 1 | Confident entry found for `lk_pc` |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| rs_valid | input | 1 | Resolved outcome present |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |
| rs_alloc | input | 1 | Main predictor mispredicted; allocate if untracked |

## Verification
A run counter that is off by one shows up at the ports as an exit predicted one iteration early or one iteration late. This is visible on the first loop instance after training, so the bench compares every outcome of the trained instances. A confidence flag that is set or cleared wrongly makes `lk_hit` appear or vanish one loop instance too early or too late, and the bench samples it after each exit. A replacement error evicts the wrong branch, and this is seen at the next lookup of the branch that was used least recently.

// File: rtl/lp_pkg.sv
package lp_pkg;
  // Table action chosen for one resolve.
  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_ALLOC,
    ACT_STEP,
    ACT_EXIT
  } act_e;
endpackage

// File: rtl/lp_cam.sv
module lp_cam #(
  parameter int N = 16,
  parameter int W = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]        vld,
  input  logic [N-1:0][W-1:0] tags,
  input  logic [W-1:0]        key,
  output logic                hit,
  output logic [IW-1:0]       idx
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g] == key);
  end

  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) idx = IW'(i);
  end

  // R7: allocation never duplicates a tag, so at most one entry matches.
  always_comb a_r7_single_match: assert ($onehot0(match));
endmodule

// File: rtl/lp_lru.sv
module lp_lru #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  vld,
  output logic [IW-1:0] victim
);
  logic [N-1:0][IW-1:0] age;
  logic [N-1:0]         is_old;
  logic                 found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)        age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign is_old[g] = (age[g] == IW'(N - 1));
  end

  always_comb begin
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < N; i++)
      if (!vld[i] && !found) begin
        victim = IW'(i);
        found  = 1'b1;
      end
    if (!found)
      for (int i = 0; i < N; i++)
        if (is_old[i]) victim = IW'(i);
  end

  // R8: ages stay a permutation, so exactly one entry is the oldest.
  a_r8_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_old) == 1);
endmodule

// File: rtl/loop_predictor.sv
module loop_predictor #(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int CNT_W   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic            rs_alloc
);
  import lp_pkg::*;

  localparam int IW = $clog2(ENTRIES);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ENTRIES-1:0]            vld, dir, lrn, conf;
  logic [ENTRIES-1:0][PC_W-1:0]  tag;
  logic [ENTRIES-1:0][CNT_W-1:0] cnt, lim;

  logic          lk_m, rs_m;
  logic [IW-1:0] lk_idx, rs_idx, victim, wr_idx;
  act_e          act;

  lp_cam #(.N(ENTRIES), .W(PC_W)) i_cam_lk (
    .vld(vld), .tags(tag), .key(lk_pc), .hit(lk_m), .idx(lk_idx));

  lp_cam #(.N(ENTRIES), .W(PC_W)) i_cam_rs (
    .vld(vld), .tags(tag), .key(rs_pc), .hit(rs_m), .idx(rs_idx));

  lp_lru #(.N(ENTRIES)) i_lru (
    .clk(clk), .rst_n(rst_n), .touch(act != ACT_IDLE), .touch_idx(wr_idx),
    .vld(vld), .victim(victim));

  // Lookup: combinational read of the registered table.
  always_comb begin
    lk_hit   = lk_valid && lk_m && conf[lk_idx];
    lk_taken = lk_hit && ((cnt[lk_idx] == lim[lk_idx]) ? ~dir[lk_idx] : dir[lk_idx]);
  end

  // Resolve: classify the outcome.
  always_comb begin
    if (!rs_valid)                 act = ACT_IDLE;
    else if (rs_m)                 act = (rs_taken == dir[rs_idx]) ? ACT_STEP : ACT_EXIT;
    else if (rs_alloc)             act = ACT_ALLOC;
    else                           act = ACT_IDLE;
    wr_idx = (act == ACT_ALLOC) ? victim : rs_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      dir  <= '0;
      lrn  <= '0;
      conf <= '0;
      tag  <= '0;
      cnt  <= '0;
      lim  <= '0;
    end else begin
      unique case (act)
        ACT_ALLOC: begin
          vld[wr_idx]  <= 1'b1;
          tag[wr_idx]  <= rs_pc;
          cnt[wr_idx]  <= CNT_W'(1);
          lim[wr_idx]  <= '0;
          dir[wr_idx]  <= rs_taken;
          lrn[wr_idx]  <= 1'b0;
          conf[wr_idx] <= 1'b0;
        end
        ACT_STEP: begin
          if (cnt[wr_idx] != CNT_MAX) cnt[wr_idx] <= cnt[wr_idx] + 1'b1;
        end
        ACT_EXIT: begin
          cnt[wr_idx] <= '0;
          if (lrn[wr_idx] && cnt[wr_idx] == lim[wr_idx]) begin
            conf[wr_idx] <= 1'b1;
          end else begin
            lim[wr_idx]  <= cnt[wr_idx];
            lrn[wr_idx]  <= 1'b1;
            conf[wr_idx] <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  // Index of the entry written in the previous cycle, for the checks below.
  logic [IW-1:0] chk_idx;
  always_ff @(posedge clk) chk_idx <= wr_idx;

  a_r2_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP && cnt[wr_idx] != CNT_MAX) |=>
      cnt[chk_idx] == CNT_W'($past(cnt[wr_idx]) + 1'b1));

  a_r3_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_EXIT) |=> cnt[chk_idx] == '0);

  a_r5_relearn_drops_conf: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_EXIT && !(lrn[wr_idx] && cnt[wr_idx] == lim[wr_idx])) |=>
      !conf[chk_idx] && lim[chk_idx] == $past(cnt[wr_idx]));

  a_r6_repeat_sets_conf: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_EXIT && lrn[wr_idx] && cnt[wr_idx] == lim[wr_idx]) |=>
      conf[chk_idx] && $stable(lim[chk_idx]));

  a_r10_idle_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_IDLE) |=> $stable(vld));
endmodule

// File: tb/test_loop_predictor.sv
module test_loop_predictor;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_hit, lk_taken;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_pc = '0;
  logic        rs_taken = 1'b0;
  logic        rs_alloc = 1'b0;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  loop_predictor i_loop_predictor (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_alloc(rs_alloc));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic look(input logic [31:0] pc, output bit hit, output bit tk);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_pc    = pc;
    #1;
    hit = lk_hit;
    tk  = lk_taken;
    lk_valid = 1'b0;
  endtask

  task automatic res(input logic [31:0] pc, input bit tk, input bit al);
    @(negedge clk);
    rs_valid = 1'b1;
    rs_pc    = pc;
    rs_taken = tk;
    rs_alloc = al;
    @(posedge clk);
    #1;
    rs_valid = 1'b0;
    rs_alloc = 1'b0;
  endtask

  // Runs loop instances of `trip` taken outcomes and one not-taken exit.
  // Inside an instance a hit is expected from instance `first` on; after
  // its exit, from instance first-1 on.
  task automatic run_loop(input logic [31:0] pc, input int trip, input int insts,
                          input int first, input string req);
    bit h, t;
    for (int n = 0; n < insts; n++) begin
      int wrong = 0;
      for (int k = 0; k <= trip; k++) begin
        bit actual = (k < trip);
        look(pc, h, t);
        if (h != (n >= first)) wrong++;
        else if (h && t != actual) wrong++;
        res(pc, actual, 1'b1);
      end
      check(wrong == 0, req, wrong, 0);
      look(pc, h, t);
      check(h == (n >= first - 1), "R6 hit after exit", h, n >= first - 1);
    end
  endtask

  task automatic t_reset();
    bit h, t;
    do_reset();
    look(32'h0000_1000, h, t);
    check(!h && !t, "R1 no hit after reset", {h, t}, 0);
  endtask

  task automatic t_trips();
    do_reset();
    run_loop(32'h2000, 3, 5, 2, "R4/R6/R2/R3 trip 3");
    run_loop(32'h2010, 7, 4, 2, "R4/R7 trip 7");
    run_loop(32'h2020, 200, 4, 2, "R9 trip 200");
  endtask

  task automatic t_relearn();
    bit h, t;
    do_reset();
    run_loop(32'h3000, 5, 3, 2, "R4 trip 5");
    // One instance of trip 6 against a limit of 5.
    for (int k = 0; k <= 6; k++) begin
      if (k == 5) begin
        look(32'h3000, h, t);
        check(h && !t, "R4 exit predicted at old limit", {h, t}, 2);
      end
      res(32'h3000, k < 6, 1'b1);
    end
    look(32'h3000, h, t);
    check(!h, "R5 confidence cleared on new trip", h, 0);
    run_loop(32'h3000, 6, 2, 1, "R5 relearned trip 6");
    // Untracked branch without allocation leaves no trace.
    for (int n = 0; n < 3; n++)
      for (int k = 0; k <= 2; k++) res(32'h3100, k < 2, 1'b0);
    look(32'h3100, h, t);
    check(!h, "R10 untracked stays untracked", h, 0);
    look(32'h3000, h, t);
    check(h, "R10 tracked entry kept", h, 1);
  endtask

  task automatic t_lru();
    bit h, t;
    int miss = 0;
    do_reset();
    for (int i = 0; i < 16; i++)
      for (int n = 0; n < 2; n++) begin
        res(32'h4000 + i * 4, 1'b1, 1'b1);
        res(32'h4000 + i * 4, 1'b0, 1'b1);
      end
    for (int i = 0; i < 16; i++) begin
      look(32'h4000 + i * 4, h, t);
      if (!h) miss++;
    end
    check(miss == 0, "R8 free entries filled first", miss, 0);
    res(32'h4000, 1'b1, 1'b1);
    res(32'h4100, 1'b1, 1'b1);
    look(32'h4004, h, t);
    check(!h, "R8 oldest entry evicted", h, 0);
    look(32'h4000, h, t);
    check(h, "R8 recently used entry kept", h, 1);
    look(32'h4008, h, t);
    check(h, "R8 other entry kept", h, 1);
    look(32'h4100, h, t);
    check(!h, "R7 new entry not confident", h, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_trips();
    t_relearn();
    t_lru();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule